// File: doc/BRIEF.md
# GPIO interrupt status unit

This block turns a bank of already-synchronized GPIO input levels into interrupt events. Every pin has its own trigger setting: a mode bit picks edge or level detection, and an invert bit picks which edge or which level is active. A third per-pin bit turns sensing off for that pin. An event sets a sticky status bit for the pin. The status bits and the per-pin enable bits are packed into 32-bit words on a small register bus. A single interrupt line goes high while any pin has both its status bit and its enable bit set.

Software reads the status words to find out which pins fired. It clears a serviced pin by writing a 1 to that pin's status bit. The clear changes only the bits written as 1, so an edge that arrives on another pin while software is servicing is kept. When an event and a clear hit the same bit in the same cycle, the event wins. This is how a level that is still active keeps its pin asserted.

The per-pin trigger and sense-disable settings come in as input vectors from the surrounding configuration logic. Reads on the bus are combinational. Writes take effect on the rising clock edge.

Top module: `gpio_irq_unit`

## Requirements
- R1: While reset is active, and at the first clock after reset, every status bit and every enable bit reads 0 and `irq_o` is low.
- R2: Pin n sits in word n/32 at bit n%32. `bus_addr_i[2]` selects the bank: 0 is status and 1 is enable. `bus_addr_i[1:0]` is the word index. Word index 3 reads 0 and ignores writes. Bits above the last pin (word 2, bit 31) always read 0.
- R3: With the mode bit at 0 (edge) and invert at 0, a pin sets its status bit on the clock edge where a 1 is first sampled after a 0. With invert at 1, the bit sets where a 0 is first sampled after a 1. No other change sets it.
- R4: With the mode bit at 1 (level), the active level is low when invert is 0 and high when invert is 1. The status bit sets on every clock edge at which the active level is sampled.
- R5: An edge event needs a previous sample taken while sensing was on. The first sample after reset produces no edge event, and neither does the first sample after sensing is switched back on.
- R6: While a pin's sense-disable bit is 1, the pin produces no events and its status bit does not set.
- R7: A status write clears each bit written as 1 and leaves each bit written as 0 unchanged. Writing all ones clears the whole word.
- R8: When an event and a clear reach the same status bit in the same cycle, the bit ends up set.
- R9: An enable write loads the word, and the value reads back. `irq_o` is the OR over all pins of status AND enable, registered once, so it follows one cycle after the status and enable bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pin_level_i | input | 95 | Synchronized pin levels |
| trig_level_i | input | 95 | Per-pin mode: 0 edge, 1 level |
| trig_inv_i | input | 95 | Per-pin invert of the trigger sense |
| sense_off_i | input | 95 | Per-pin input-sense disable |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | 3 | Bank select (bit 2) and word index (bits 1:0) |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Combinational read data for `bus_addr_i` |
| irq_o | output | 1 | Combined interrupt, registered |

## Verification
The bench targets the inverted encodings first. A design that swapped them would show the falling edge as rising, or would treat level-low as the sense with invert set. Reset release with a pin already high, and sensing switched back on with a pin high, are both driven on purpose. A design that seeded its previous sample wrongly would report a false rising edge there. The bench also drives a clear on a pin whose level is still active, to catch a design that lets the clear win. It drives writes of zeros and writes to the unused word, to catch any write that disturbs bits it should leave alone. The bench changes enables and reads `irq_o` in the cycle after, so an unregistered or unmasked OR shows up as a mismatch.

// File: rtl/gpio_irq_pkg.sv
`timescale 1ns/1ps
package gpio_irq_pkg;

  typedef enum logic {
    BANK_STATUS = 1'b0,
    BANK_ENABLE = 1'b1
  } bank_e;

  // Event for one pin in one cycle; mode=1 is level, inv flips the sense.
  function automatic logic pin_event(
    input logic lvl,
    input logic prev,
    input logic prev_ok,
    input logic mode,
    input logic inv
  );
    logic active;
    if (mode) begin
      active = (lvl == inv);
    end else begin
      active = prev_ok && (lvl ^ inv) && !(prev ^ inv);
    end
    return active;
  endfunction

  function automatic int unsigned words_for(input int unsigned pins, input int unsigned width);
    return (pins + width - 1) / width;
  endfunction

endpackage

// File: rtl/gpio_irq_sense.sv
`timescale 1ns/1ps
module gpio_irq_sense
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NUM_PINS = 95
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pin_level,
  input  logic [NUM_PINS-1:0] trig_level,
  input  logic [NUM_PINS-1:0] trig_inv,
  input  logic [NUM_PINS-1:0] sense_off,
  output logic [NUM_PINS-1:0] evt_vec
);

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    logic prev_q;
    logic ok_q;

    // Previous sample is valid only once sensing has been on for a full cycle.
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        prev_q <= 1'b0;
        ok_q   <= 1'b0;
      end else if (sense_off[p]) begin
        ok_q   <= 1'b0;
      end else begin
        prev_q <= pin_level[p];
        ok_q   <= 1'b1;
      end
    end

    assign evt_vec[p] = !sense_off[p] &&
                        pin_event(pin_level[p], prev_q, ok_q, trig_level[p], trig_inv[p]);
  end

endmodule

// File: rtl/gpio_irq_word.sv
`timescale 1ns/1ps
module gpio_irq_word #(
  parameter int unsigned WORD_W    = 32,
  parameter int unsigned LIVE_BITS = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] evt_bits,
  input  logic [WORD_W-1:0] clr_bits,
  input  logic              en_we,
  input  logic [WORD_W-1:0] en_wdata,
  output logic [WORD_W-1:0] status_q,
  output logic [WORD_W-1:0] enable_q
);

  logic [WORD_W-1:0] live;

  for (genvar b = 0; b < WORD_W; b++) begin : g_live
    assign live[b] = (b < LIVE_BITS);
  end

  // Clear first, then set: a same-cycle event survives the clear.
  function automatic logic [WORD_W-1:0] next_status(
    input logic [WORD_W-1:0] cur,
    input logic [WORD_W-1:0] clr,
    input logic [WORD_W-1:0] evt,
    input logic [WORD_W-1:0] mask
  );
    return ((cur & ~clr) | evt) & mask;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      enable_q <= '0;
    end else begin
      status_q <= next_status(status_q, clr_bits, evt_bits, live);
      if (en_we) begin
        enable_q <= en_wdata & live;
      end
    end
  end

endmodule

// File: rtl/gpio_irq_bus.sv
`timescale 1ns/1ps
module gpio_irq_bus
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NUM_WORDS = 3,
  parameter int unsigned WORD_W    = 32,
  parameter int unsigned IDX_W     = 2
) (
  input  logic                             bus_wr,
  input  logic [IDX_W:0]                   bus_addr,
  input  logic [WORD_W-1:0]                bus_wdata,
  input  logic [NUM_WORDS-1:0][WORD_W-1:0] status_words,
  input  logic [NUM_WORDS-1:0][WORD_W-1:0] enable_words,
  output logic [NUM_WORDS-1:0][WORD_W-1:0] clr_words,
  output logic [NUM_WORDS-1:0]             en_we,
  output logic [WORD_W-1:0]                bus_rdata
);

  logic [IDX_W-1:0] idx;
  bank_e            bank;

  assign idx  = bus_addr[IDX_W-1:0];
  assign bank = bank_e'(bus_addr[IDX_W]);

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_dec
    logic sel;
    assign sel          = bus_wr && (idx == IDX_W'(w));
    assign clr_words[w] = (sel && bank == BANK_STATUS) ? bus_wdata : '0;
    assign en_we[w]     = sel && bank == BANK_ENABLE;
  end

  always_comb begin
    bus_rdata = '0;
    for (int w = 0; w < int'(NUM_WORDS); w++) begin
      if (idx == IDX_W'(w)) begin
        bus_rdata = (bank == BANK_ENABLE) ? enable_words[w] : status_words[w];
      end
    end
  end

endmodule

// File: rtl/gpio_irq_unit.sv
`timescale 1ns/1ps
module gpio_irq_unit
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NUM_PINS = 95,
  parameter int unsigned WORD_W   = 32,
  localparam int unsigned NUM_WORDS = words_for(NUM_PINS, WORD_W),
  localparam int unsigned IDX_W     = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1,
  localparam int unsigned ADDR_W    = IDX_W + 1,
  localparam int unsigned PAD_W     = NUM_WORDS * WORD_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pin_level_i,
  input  logic [NUM_PINS-1:0] trig_level_i,
  input  logic [NUM_PINS-1:0] trig_inv_i,
  input  logic [NUM_PINS-1:0] sense_off_i,
  input  logic                bus_wr_i,
  input  logic [ADDR_W-1:0]   bus_addr_i,
  input  logic [WORD_W-1:0]   bus_wdata_i,
  output logic [WORD_W-1:0]   bus_rdata_o,
  output logic                irq_o
);

  // Named internal events, brought out for the checker.
  logic [NUM_PINS-1:0] evt_vec;
  logic [PAD_W-1:0]    evt_pad;
  logic [PAD_W-1:0]    soff_pad;
  logic [PAD_W-1:0]    stat_flat;
  logic [PAD_W-1:0]    en_flat;
  logic [PAD_W-1:0]    clr_flat;
  logic                irq_q;

  logic [NUM_WORDS-1:0][WORD_W-1:0] evt_words;
  logic [NUM_WORDS-1:0][WORD_W-1:0] stat_words;
  logic [NUM_WORDS-1:0][WORD_W-1:0] en_words;
  logic [NUM_WORDS-1:0][WORD_W-1:0] clr_words;
  logic [NUM_WORDS-1:0]             en_we;

  gpio_irq_sense #(
    .NUM_PINS (NUM_PINS)
  ) sense_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .pin_level  (pin_level_i),
    .trig_level (trig_level_i),
    .trig_inv   (trig_inv_i),
    .sense_off  (sense_off_i),
    .evt_vec    (evt_vec)
  );

  always_comb begin
    evt_pad                 = '0;
    evt_pad[NUM_PINS-1:0]   = evt_vec;
    soff_pad                = '0;
    soff_pad[NUM_PINS-1:0]  = sense_off_i;
  end

  assign evt_words = evt_pad;

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    localparam int unsigned LIVE = (w < NUM_WORDS - 1) ? WORD_W : (NUM_PINS - w * WORD_W);
    gpio_irq_word #(
      .WORD_W    (WORD_W),
      .LIVE_BITS (LIVE)
    ) word_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .evt_bits (evt_words[w]),
      .clr_bits (clr_words[w]),
      .en_we    (en_we[w]),
      .en_wdata (bus_wdata_i),
      .status_q (stat_words[w]),
      .enable_q (en_words[w])
    );
  end

  gpio_irq_bus #(
    .NUM_WORDS (NUM_WORDS),
    .WORD_W    (WORD_W),
    .IDX_W     (IDX_W)
  ) bus_i (
    .bus_wr       (bus_wr_i),
    .bus_addr     (bus_addr_i),
    .bus_wdata    (bus_wdata_i),
    .status_words (stat_words),
    .enable_words (en_words),
    .clr_words    (clr_words),
    .en_we        (en_we),
    .bus_rdata    (bus_rdata_o)
  );

  assign stat_flat = stat_words;
  assign en_flat   = en_words;
  assign clr_flat  = clr_words;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
    end else begin
      irq_q <= |(stat_flat & en_flat);
    end
  end

  assign irq_o = irq_q;

endmodule

// File: rtl/gpio_irq_chk.sv
`timescale 1ns/1ps
module gpio_irq_chk #(
  parameter int unsigned PAD_W = 96
) (
  input logic             clk,
  input logic             rst_n,
  input logic             irq_o,
  input logic [PAD_W-1:0] stat_flat,
  input logic [PAD_W-1:0] en_flat,
  input logic [PAD_W-1:0] clr_flat,
  input logic [PAD_W-1:0] evt_pad,
  input logic [PAD_W-1:0] soff_pad
);

  // R1
  reset_state_chk: assert property (@(posedge clk)
    !rst_n |=> (stat_flat == '0 && en_flat == '0 && !irq_o));

  // R6
  sense_off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_pad & soff_pad) == '0);

  // R8
  event_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(evt_pad) & ~stat_flat) == '0));

  // R3
  no_spurious_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((stat_flat & ~$past(stat_flat) & ~$past(evt_pad)) == '0));

  // R7
  clear_only_by_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(stat_flat) & ~stat_flat & ~$past(clr_flat)) == '0));

  // R9
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat_flat & en_flat) == '0) |=> !irq_o);

  // R9
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat_flat & en_flat) != '0) |=> irq_o);

endmodule

bind gpio_irq_unit gpio_irq_chk #(
  .PAD_W (PAD_W)
) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .irq_o     (irq_o),
  .stat_flat (stat_flat),
  .en_flat   (en_flat),
  .clr_flat  (clr_flat),
  .evt_pad   (evt_pad),
  .soff_pad  (soff_pad)
);

// File: tb/gpio_irq_unit_tb.sv
`timescale 1ns/1ps
module gpio_irq_unit_tb_top;

  localparam int NP   = 95;
  localparam int PADW = 96;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NP-1:0] lvl = '0;
  logic [NP-1:0] tlev = '0;
  logic [NP-1:0] tinv = '0;
  logic [NP-1:0] soff = '0;
  logic          bus_wr = 1'b0;
  logic [2:0]    bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic          irq;

  always #2.5 clk = ~clk;

  gpio_irq_unit dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .pin_level_i  (lvl),
    .trig_level_i (tlev),
    .trig_inv_i   (tinv),
    .sense_off_i  (soff),
    .bus_wr_i     (bus_wr),
    .bus_addr_i   (bus_addr),
    .bus_wdata_i  (bus_wdata),
    .bus_rdata_o  (bus_rdata),
    .irq_o        (irq)
  );

  // Reference model state
  logic [PADW-1:0] m_stat = '0;
  logic [PADW-1:0] m_en = '0;
  logic [NP-1:0]   m_prev = '0;
  logic [NP-1:0]   m_ok = '0;
  logic            m_irq = 1'b0;

  int  checks = 0;
  int  fails = 0;
  bit  done = 1'b0;

  // Bench's own statement of the trigger table (R3, R4, R5, R6)
  function automatic logic fires(input int p);
    if (soff[p]) return 1'b0;
    if (tlev[p]) return tinv[p] ? lvl[p] : !lvl[p];
    if (!m_ok[p]) return 1'b0;
    if (tinv[p]) return m_prev[p] && !lvl[p];
    return !m_prev[p] && lvl[p];
  endfunction

  task automatic tick();
    logic [PADW-1:0] ev;
    logic [1:0]      wi;
    ev = '0;
    if (!rst_n) begin
      m_stat = '0; m_en = '0; m_prev = '0; m_ok = '0; m_irq = 1'b0;
    end else begin
      for (int p = 0; p < NP; p++) ev[p] = fires(p);
      m_irq = |(m_stat & m_en);
      wi = bus_addr[1:0];
      if (bus_wr && wi != 2'd3) begin
        if (bus_addr[2]) begin
          m_en[wi*32 +: 32] = bus_wdata;
          m_en[PADW-1] = 1'b0;
        end else begin
          m_stat[wi*32 +: 32] = m_stat[wi*32 +: 32] & ~bus_wdata;
        end
      end
      m_stat = m_stat | ev;
      for (int p = 0; p < NP; p++) begin
        if (soff[p]) m_ok[p] = 1'b0;
        else begin m_prev[p] = lvl[p]; m_ok[p] = 1'b1; end
      end
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic check_all(input string tag);
    logic [31:0] exp;
    check({tag, " irq"}, {31'd0, irq}, {31'd0, m_irq});
    for (int w = 0; w < 4; w++) begin
      for (int b = 0; b < 2; b++) begin
        bus_addr = {b[0], w[1:0]};
        #0.2;
        if (w == 3) exp = '0;
        else exp = b[0] ? m_en[w*32 +: 32] : m_stat[w*32 +: 32];
        check($sformatf("%s bank%0d word%0d", tag, b, w), bus_rdata, exp);
      end
    end
  endtask

  task automatic wr(input logic bank, input logic [1:0] idx, input logic [31:0] data);
    bus_wr = 1'b1;
    bus_addr = {bank, idx};
    bus_wdata = data;
    tick();
    bus_wr = 1'b0;
  endtask

  initial begin
    logic [95:0] r1, r2, r3;
    void'($urandom(32'd7321));
    lvl[5] = 1'b1;
    tick(); tick();
    check_all("R1 reset");
    rst_n = 1'b1;
    tick();
    check_all("R1 R5 first sample after reset");
    tick();
    check_all("R5 steady high no edge");

    wr(1'b1, 2'd0, 32'hFFFF_FFFF);
    wr(1'b1, 2'd1, 32'hFFFF_FFFF);
    wr(1'b1, 2'd2, 32'hFFFF_FFFF);
    check_all("R9 R2 enable readback");

    lvl[0] = 1'b1; lvl[63] = 1'b1; tick();
    check_all("R3 rising edge");
    tick();
    check_all("R9 irq one cycle later");
    wr(1'b0, 2'd0, 32'h0);
    check_all("R7 zero write keeps");
    wr(1'b0, 2'd0, 32'h1);
    check_all("R7 one clears");

    tinv[32] = 1'b1; tick();
    lvl[32] = 1'b1; tick();
    check_all("R3 inverted rise ignored");
    lvl[32] = 1'b0; tick();
    check_all("R3 falling edge");

    tlev[64] = 1'b1; tlev[65] = 1'b1; tinv[65] = 1'b1; lvl[65] = 1'b1; tick();
    check_all("R4 level low and high");
    wr(1'b0, 2'd2, 32'h3);
    check_all("R8 event beats clear");
    lvl[64] = 1'b1; lvl[65] = 1'b0; tick();
    wr(1'b0, 2'd2, 32'hFFFF_FFFF);
    check_all("R4 inactive level clears");

    soff[31] = 1'b1;
    for (int k = 0; k < 4; k++) begin
      lvl[31] = ~lvl[31]; tick();
      check_all("R6 sense off");
    end
    lvl[31] = 1'b1; tick();
    soff[31] = 1'b0; tick();
    check_all("R5 re-enable no edge");
    lvl[31] = 1'b0; tick(); lvl[31] = 1'b1; tick();
    check_all("R3 edge after re-enable");

    wr(1'b1, 2'd0, 32'h0); tick(); tick();
    check_all("R9 masked word");
    wr(1'b0, 2'd3, 32'hFFFF_FFFF);
    wr(1'b1, 2'd3, 32'hFFFF_FFFF);
    check_all("R2 unused word");
    wr(1'b0, 2'd0, 32'hFFFF_FFFF);
    wr(1'b0, 2'd1, 32'hFFFF_FFFF);
    wr(1'b0, 2'd2, 32'hFFFF_FFFF);
    check_all("R7 clear all words");

    for (int i = 0; i < 2500; i++) begin
      r1 = {$urandom(), $urandom(), $urandom()};
      r2 = {$urandom(), $urandom(), $urandom()};
      r3 = {$urandom(), $urandom(), $urandom()};
      lvl = lvl ^ (r1[NP-1:0] & r2[NP-1:0] & r3[NP-1:0]);
      if (i % 60 == 0) begin
        tlev = r1[NP-1:0] & r2[NP-1:0];
        tinv = r2[NP-1:0] ^ r3[NP-1:0];
        soff = r1[NP-1:0] & r3[NP-1:0] & r2[NP-1:0];
      end
      if (($urandom() & 32'h7) == 0) begin
        bus_wr = 1'b1;
        bus_addr = 3'($urandom());
        bus_wdata = $urandom();
      end
      tick();
      bus_wr = 1'b0;
      check_all("R3 R4 R6 R7 R8 R9 random");
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #900000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule